// File: doc/BRIEF.md
# Edge-Triggered High-Side Gate Pulse Link

This block carries one high-side gate command across an isolation barrier without sending the level itself. On the sending side the active-low command is watched for edges. A high-to-low edge (switch on requested) fires a short active-low pulse on the set channel. A low-to-high edge fires a short active-low pulse on the clear channel. Only these two narrow pulses cross the barrier, so the crossing draws current for a few cycles per edge and not for the whole on-time.

On the far side a set/clear latch with active-low inputs rebuilds the gate level from the two pulse channels. The pulse width is a parameter in clock cycles and is meant to be much shorter than a PWM period. If an opposite edge arrives while a pulse is still running, the running pulse is cut off on the same clock edge that starts the new one, so both channels are never active together. The latch gives the clear input priority and holds the gate off from reset until the first set pulse.

Top module: `hs_gate_pulse_link`

## Requirements
- R1: While `rst_n` is low, `gate_on` is 0 and both `set_pulse_n` and `clr_pulse_n` are 1 (idle).
- R2: When `hs_cmd_n` goes from 1 to 0, `set_pulse_n` is 0 for exactly `PULSE_CYC` cycles, starting after the first rising clock edge that sees the new value, unless it is cut short under R5.
- R3: When `hs_cmd_n` goes from 0 to 1, `clr_pulse_n` is 0 for exactly `PULSE_CYC` cycles, starting after the first rising clock edge that sees the new value, unless it is cut short under R5.
- R4: `set_pulse_n` and `clr_pulse_n` are never 0 in the same cycle.
- R5: An edge of the opposite direction that arrives during a pulse returns the running channel to 1 on the same clock edge that starts the other channel.
- R6: `gate_on` (1 = switch on) becomes 1 one cycle after `set_pulse_n` is first 0, becomes 0 one cycle after `clr_pulse_n` is first 0, and keeps its value while both channels are 1.
- R7: Inside the receive latch, a low clear input forces the gate off on the next edge even if the set input is low at the same time.
- R8: While `hs_cmd_n` holds steady, no new pulse starts on either channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both the sending and the receiving logic |
| rst_n | input | 1 | Asynchronous reset, active low |
| hs_cmd_n | input | 1 | High-side command, active low (0 requests the switch on) |
| set_pulse_n | output | 1 | Set channel that crosses the barrier, active low |
| clr_pulse_n | output | 1 | Clear channel that crosses the barrier, active low |
| gate_on | output | 1 | Rebuilt gate level, 1 = switch on |

## Verification
The assertions assume that `hs_cmd_n` is synchronous to `clk` and changes at most once per cycle. The bench respects this by driving the command only on the falling clock edge. The assertions also assume a `PULSE_CYC` of at least 1. The stimulus sweeps every pair of low-hold and high-hold lengths from one cycle up to a few cycles beyond `PULSE_CYC`. This covers edges inside a running pulse, edges exactly at its end, and edges after it. The clear-wins case of R7 cannot occur at the ports, so only the latch assertion covers it.

// File: rtl/lsp_pkg.sv
package lsp_pkg;

  // Index of each pulse channel inside the encoder's channel array.
  localparam int unsigned CH_SET = 0;
  localparam int unsigned CH_CLR = 1;
  localparam int unsigned N_CH   = 2;

  // Width of a down-counter that must hold the value pw.
  function automatic int unsigned lsp_cnt_bits(input int unsigned pw);
    int unsigned b;
    b = $clog2(pw + 1);
    return (b < 1) ? 1 : b;
  endfunction

endpackage

// File: rtl/lsp_edge_det.sv
module lsp_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_n,
  output logic fall_evt,
  output logic rise_evt
);
  logic prev_q;

  // The reset value of 1 means the command is taken as off at reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= lvl_n;
  end

  assign fall_evt = prev_q & ~lvl_n;
  assign rise_evt = ~prev_q & lvl_n;
endmodule

// File: rtl/lsp_oneshot.sv
module lsp_oneshot #(
  parameter int unsigned PW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic abort,
  output logic pulse_n
);
  localparam int unsigned CW = lsp_pkg::lsp_cnt_bits(PW);
  localparam logic [CW-1:0] LOAD = CW'(PW);

  logic [CW-1:0] cnt_q;

  // fire reloads the count, abort cuts the pulse, otherwise count down to 0.
  function automatic logic [CW-1:0] next_cnt(input logic [CW-1:0] c,
                                             input logic f, input logic a);
    if (f)              return LOAD;
    else if (a)         return '0;
    else if (c != '0)   return c - 1'b1;
    else                return c;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= next_cnt(cnt_q, fire, abort);
  end

  assign pulse_n = (cnt_q == '0);

  AST_FIRE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !pulse_n);  // R2
  AST_ABORT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && !fire) |=> pulse_n);  // R5
endmodule

// File: rtl/lsp_rx_latch.sv
module lsp_rx_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic s_n,
  input  logic r_n,
  output logic gate
);
  // Clear has priority, so a low clear input always wins over set.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gate <= 1'b0;
    else if (!r_n) gate <= 1'b0;
    else if (!s_n) gate <= 1'b1;
  end

  AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    !r_n |=> !gate);  // R7
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (!s_n && r_n) |=> gate);  // R6
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (s_n && r_n) |=> $stable(gate));  // R6
endmodule

// File: rtl/hs_gate_pulse_link.sv
module hs_gate_pulse_link #(
  parameter int unsigned PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_cmd_n,
  output logic set_pulse_n,
  output logic clr_pulse_n,
  output logic gate_on
);
  import lsp_pkg::*;

  logic fall_evt;
  logic rise_evt;
  logic [N_CH-1:0] ch_fire;
  logic [N_CH-1:0] ch_pulse_n;

  lsp_edge_det u_edge (
    .clk      (clk),
    .rst_n    (rst_n),
    .lvl_n    (hs_cmd_n),
    .fall_evt (fall_evt),
    .rise_evt (rise_evt)
  );

  assign ch_fire[CH_SET] = fall_evt;
  assign ch_fire[CH_CLR] = rise_evt;

  // Each channel is aborted by the trigger of the other channel.
  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    lsp_oneshot #(.PW(PULSE_CYC)) u_shot (
      .clk     (clk),
      .rst_n   (rst_n),
      .fire    (ch_fire[g]),
      .abort   (ch_fire[N_CH-1-g]),
      .pulse_n (ch_pulse_n[g])
    );
  end

  assign set_pulse_n = ch_pulse_n[CH_SET];
  assign clr_pulse_n = ch_pulse_n[CH_CLR];

  lsp_rx_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n),
    .s_n   (set_pulse_n),
    .r_n   (clr_pulse_n),
    .gate  (gate_on)
  );

  AST_SET_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |=> (!set_pulse_n && clr_pulse_n));  // R2
  AST_CLR_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    rise_evt |=> (!clr_pulse_n && set_pulse_n));  // R3
  AST_CH_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (set_pulse_n || clr_pulse_n));  // R4
  AST_STEADY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!fall_evt && !rise_evt && set_pulse_n && clr_pulse_n)
      |=> (set_pulse_n && clr_pulse_n));  // R8
endmodule

// File: tb/tb_hs_gate_pulse_link.sv
module tb_hs_gate_pulse_link;
  localparam int unsigned PW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hs_cmd_n = 1'b1;
  logic set_pulse_n, clr_pulse_n, gate_on;

  int n_run = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 1'b0;

  // Model state: latest edge (clock index, 1 = fall/set) and previous expectations.
  int  ev_edge = -1000;
  bit  ev_fall = 1'b0;
  bit  exp_set_prev = 1'b0;
  bit  exp_clr_prev = 1'b0;
  bit  exp_gate = 1'b0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hs_gate_pulse_link #(.PULSE_CYC(PW)) dut (
    .clk(clk), .rst_n(rst_n), .hs_cmd_n(hs_cmd_n),
    .set_pulse_n(set_pulse_n), .clr_pulse_n(clr_pulse_n), .gate_on(gate_on)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s cyc=%0d actual=%b expected=%b", req, cyc, act, exp);
    end
  endtask

  // Called at a falling edge: checks outputs after the latest rising edge.
  task automatic check_now();
    int age;
    bit s_exp, c_exp;
    age = (cyc - 1) - ev_edge;
    s_exp = ev_fall && (age >= 0) && (age < int'(PW));
    c_exp = !ev_fall && (age >= 0) && (age < int'(PW));
    // R6: gate follows the previous cycle's channels, clear first.
    if (exp_clr_prev)      exp_gate = 1'b0;
    else if (exp_set_prev) exp_gate = 1'b1;
    chk(ev_fall ? "R2/R5 set" : "R8/R5 set", set_pulse_n, !s_exp);
    chk(ev_fall ? "R8/R5 clr" : "R3/R5 clr", clr_pulse_n, !c_exp);
    chk("R4 exclusive", set_pulse_n | clr_pulse_n, 1'b1);
    chk("R6 gate", gate_on, exp_gate);
    exp_set_prev = s_exp;
    exp_clr_prev = c_exp;
  endtask

  task automatic drive(input logic v);
    if (v !== hs_cmd_n) begin
      ev_edge = cyc;   // edge index of the next rising clock edge
      ev_fall = (v == 1'b0);
    end
    hs_cmd_n = v;
  endtask

  task automatic hold(input logic v, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_now();
      if (i == 0) drive(v);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 set idle", set_pulse_n, 1'b1);
    chk("R1 clr idle", clr_pulse_n, 1'b1);
    chk("R1 gate off", gate_on, 1'b0);
    rst_n = 1'b1;
    hold(1'b1, 6);   // R8: steady off, no pulses
    for (int lo = 1; lo <= int'(PW) + 3; lo++) begin
      for (int hi = 1; hi <= int'(PW) + 3; hi++) begin
        hold(1'b0, lo);
        hold(1'b1, hi);
      end
    end
    hold(1'b0, 12);  // R8: steady on
    hold(1'b1, 12);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule